// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps the VLAN membership table of a seven-port switch and runs the commands that maintain it. Each table slot holds a 12-bit VLAN identifier, an independent-learning enable and a two-bit egress mode for every port. Two words form the interface. The entry word is a staging register. The command word names an operation and a target VLAN, and it reports a busy flag and a full flag.

To change the table, the caller first writes the staging register. It then writes the command word with the busy bit set and one of three operation codes. A load stores the staged entry under the VLAN. A purge removes that VLAN. A read copies the stored entry into the staging register. The engine checks every slot in turn, one slot per clock, and then completes the operation in a single commit cycle. It clears busy when the operation is done. Busy therefore stays high for a fixed number of cycles, and the caller only needs to poll that bit.

Top module: `vlan_tbl_engine`

## Requirements
- R1: After reset, busy and full read 0, the staging register reads all zeros, and every slot is empty.
- R2: The command word layout is: busy at bit 15, full at bit 14, operation at bits 13:12 (01 load, 10 purge, 11 read), and the VLAN identifier at bits 11:0. A write of this word while idle, with bit 15 set and a nonzero operation, sets busy in the next cycle.
- R3: While busy is high, writes to the staging register and to the command word are ignored.
- R4: The staging word layout is: valid at bit 15, learning enable at bit 14, and two bits of egress mode per port at bits 2p+1:2p. A load followed by a read of the same VLAN returns valid=1 together with the stored learning bit and egress modes.
- R5: A load to a VLAN that is already stored overwrites that slot in place. It uses no new slot and does not set full.
- R6: A read of a VLAN that is not stored returns valid=0 and learning=0, with every port set to 11 (not a member).
- R7: A purge removes the VLAN, so a later read misses. The freed slot can then be taken by a new load.
- R8: A load that matches no stored VLAN and finds no empty slot sets full and leaves the table unchanged. Full changes only when a command completes, and it is cleared when the next command completes.
- R9: Busy stays high for exactly DEPTH+1 cycles per command: DEPTH scan cycles and one commit cycle.
- R10: A command write with bit 15 clear, or with operation 00, starts nothing and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entWr | input | 1 | Write strobe for the staging register |
| entWrData | input | 16 | Staging word to write |
| cmdWr | input | 1 | Write strobe for the command word |
| cmdWrData | input | 16 | Command word to write |
| entRdData | output | 16 | Current staging register |
| cmdRdData | output | 16 | Busy, full, latched operation and VLAN identifier |

## Verification
The assertions assume that the caller treats busy as the only completion signal, and that a write made during busy counts as a stray write rather than a new request. The hold properties rely on this. The stimulus waits for busy to fall before it reads results or issues the next real command. It also makes deliberate stray writes while busy is high, to exercise the ignore path. Reset is held long enough for every slot to clear before the first command.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam logic [1:0] OP_NONE  = 2'b00;
  localparam logic [1:0] OP_LOAD  = 2'b01;
  localparam logic [1:0] OP_PURGE = 2'b10;
  localparam logic [1:0] OP_READ  = 2'b11;

  localparam logic [1:0] EG_UNTAG = 2'b01;
  localparam logic [1:0] EG_TAG   = 2'b10;
  localparam logic [1:0] EG_NONE  = 2'b11;

  typedef struct packed {
    logic clrScan;
    logic scanEn;
    logic doLoad;
    logic doPurge;
    logic doRead;
  } vtcStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} vtcState_t;
endpackage

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VIDW  = 12,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CMDW = VIDW + 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWr,
  input  logic [CMDW-1:0] cmdWrData,
  input  logic            hitSeen,
  input  logic            freeSeen,
  output vtcStrobe_t      strobe,
  output logic [IDXW-1:0] scanIdx,
  output logic [VIDW-1:0] curVid,
  output logic            busy,
  output logic [CMDW-1:0] cmdRdData
);
  vtcState_t state;
  logic [1:0] curOp;
  logic       fullFlag;
  logic       startCmd;
  logic [1:0] wrOp;

  assign wrOp     = cmdWrData[CMDW-3:CMDW-4];
  assign startCmd = (state == ST_IDLE) && cmdWr && cmdWrData[CMDW-1] && (wrOp != OP_NONE);

  always_comb begin
    strobe         = '0;
    strobe.clrScan = startCmd;
    strobe.scanEn  = (state == ST_SCAN);
    strobe.doLoad  = (state == ST_COMMIT) && (curOp == OP_LOAD);
    strobe.doPurge = (state == ST_COMMIT) && (curOp == OP_PURGE);
    strobe.doRead  = (state == ST_COMMIT) && (curOp == OP_READ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curOp    <= OP_NONE;
      curVid   <= '0;
      scanIdx  <= '0;
      fullFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startCmd) begin
          state   <= ST_SCAN;
          curOp   <= wrOp;
          curVid  <= cmdWrData[VIDW-1:0];
          scanIdx <= '0;
        end
        ST_SCAN: begin
          if (scanIdx == IDXW'(DEPTH - 1)) state <= ST_COMMIT;
          else scanIdx <= scanIdx + 1'b1;
        end
        ST_COMMIT: begin
          state    <= ST_IDLE;
          fullFlag <= (curOp == OP_LOAD) && !hitSeen && !freeSeen;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign cmdRdData = {busy, fullFlag, curOp, curVid};
endmodule

// File: rtl/vtc_data.sv
module vtc_data
  import vtc_pkg::*;
#(
  parameter int NPORTS = 7,
  parameter int DEPTH  = 16,
  parameter int VIDW   = 12,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int ENTW  = 2 * NPORTS + 2,
  localparam int BODYW = ENTW - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  vtcStrobe_t      strobe,
  input  logic [IDXW-1:0] scanIdx,
  input  logic [VIDW-1:0] curVid,
  input  logic            busy,
  input  logic            entWr,
  input  logic [ENTW-1:0] entWrData,
  output logic            hitSeen,
  output logic            freeSeen,
  output logic [ENTW-1:0] entRdData
);
  localparam logic [ENTW-1:0] MISS_WORD = {2'b00, {NPORTS{EG_NONE}}};

  logic             slotVld [DEPTH];
  logic [VIDW-1:0]  slotVid [DEPTH];
  logic [BODYW-1:0] slotBody[DEPTH];
  logic [IDXW-1:0]  hitIdx, freeIdx;
  logic [ENTW-1:0]  entReg;
  logic [IDXW-1:0]  tgtIdx;

  assign tgtIdx = hitSeen ? hitIdx : freeIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitSeen  <= 1'b0;
      freeSeen <= 1'b0;
      hitIdx   <= '0;
      freeIdx  <= '0;
    end else if (strobe.clrScan) begin
      hitSeen  <= 1'b0;
      freeSeen <= 1'b0;
    end else if (strobe.scanEn) begin
      if (slotVld[scanIdx] && slotVid[scanIdx] == curVid) begin
        hitSeen <= 1'b1;
        hitIdx  <= scanIdx;
      end
      if (!slotVld[scanIdx] && !freeSeen) begin
        freeSeen <= 1'b1;
        freeIdx  <= scanIdx;
      end
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotVld[s]  <= 1'b0;
        slotVid[s]  <= '0;
        slotBody[s] <= '0;
      end else if (strobe.doLoad && (hitSeen || freeSeen) && tgtIdx == IDXW'(s)) begin
        slotVld[s]  <= 1'b1;
        slotVid[s]  <= curVid;
        slotBody[s] <= entReg[BODYW-1:0];
      end else if (strobe.doPurge && hitSeen && hitIdx == IDXW'(s)) begin
        slotVld[s]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) entReg <= '0;
    else if (strobe.doRead) entReg <= hitSeen ? {1'b1, slotBody[hitIdx]} : MISS_WORD;
    else if (entWr && !busy) entReg <= entWrData;
  end

  assign entRdData = entReg;
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine
  import vtc_pkg::*;
#(
  parameter int NPORTS = 7,
  parameter int DEPTH  = 16,
  parameter int VIDW   = 12,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int ENTW  = 2 * NPORTS + 2,
  localparam int CMDW  = VIDW + 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            entWr,
  input  logic [ENTW-1:0] entWrData,
  input  logic            cmdWr,
  input  logic [CMDW-1:0] cmdWrData,
  output logic [ENTW-1:0] entRdData,
  output logic [CMDW-1:0] cmdRdData
);
  vtcStrobe_t      strobe;
  logic [IDXW-1:0] scanIdx;
  logic [VIDW-1:0] curVid;
  logic            busy, hitSeen, freeSeen;

  vtc_ctrl #(.DEPTH(DEPTH), .VIDW(VIDW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWrData(cmdWrData),
    .hitSeen(hitSeen), .freeSeen(freeSeen), .strobe(strobe),
    .scanIdx(scanIdx), .curVid(curVid), .busy(busy), .cmdRdData(cmdRdData)
  );

  vtc_data #(.NPORTS(NPORTS), .DEPTH(DEPTH), .VIDW(VIDW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIdx(scanIdx),
    .curVid(curVid), .busy(busy), .entWr(entWr), .entWrData(entWrData),
    .hitSeen(hitSeen), .freeSeen(freeSeen), .entRdData(entRdData)
  );
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
  parameter int DEPTH = 16,
  parameter int ENTW  = 16,
  parameter int CMDW  = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdWr,
  input logic [CMDW-1:0] cmdWrData,
  input logic [ENTW-1:0] entRdData,
  input logic [CMDW-1:0] cmdRdData
);
  localparam int CNTW = $clog2(DEPTH + 2) + 1;
  logic busy, full, validStart;
  logic [CNTW-1:0] busyCnt;

  assign busy       = cmdRdData[CMDW-1];
  assign full       = cmdRdData[CMDW-2];
  assign validStart = cmdWr && cmdWrData[CMDW-1] && (cmdWrData[CMDW-3:CMDW-4] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= '0;
    else busyCnt <= busyCnt + 1'b1;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && validStart) |=> busy);
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !validStart) |=> !busy);
  p_entry_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(entRdData));
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdRdData[CMDW-3:0]));
  p_busy_max_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CNTW'(DEPTH + 1)));
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyCnt) == CNTW'(DEPTH)));
  p_full_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (full != $past(full)) |-> $fell(busy));
endmodule

bind vlan_tbl_engine vtc_checker #(.DEPTH(DEPTH), .ENTW(ENTW), .CMDW(CMDW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWrData(cmdWrData),
  .entRdData(entRdData), .cmdRdData(cmdRdData)
);

// File: tb/vlan_tbl_engine_bench.sv
module vlan_tbl_engine_bench;
  localparam int NPORTS = 7;
  localparam int DEPTH  = 16;
  localparam int ENTW   = 2 * NPORTS + 2;
  localparam int CMDW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic entWr = 1'b0;
  logic [ENTW-1:0] entWrData = '0;
  logic cmdWr = 1'b0;
  logic [CMDW-1:0] cmdWrData = '0;
  logic [ENTW-1:0] entRdData;
  logic [CMDW-1:0] cmdRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vlan_tbl_engine u_vlan_tbl_engine (
    .clk(clk), .rstN(rstN), .entWr(entWr), .entWrData(entWrData),
    .cmdWr(cmdWr), .cmdWrData(cmdWrData), .entRdData(entRdData), .cmdRdData(cmdRdData)
  );

  localparam logic [1:0] LOAD = 2'b01, PURGE = 2'b10, READ = 2'b11;
  localparam logic [ENTW-1:0] MISS = {2'b00, {NPORTS{2'b11}}};

  function automatic logic [ENTW-1:0] mkEntry(input int seed);
    logic [ENTW-1:0] e;
    e = '0;
    e[ENTW-2] = seed[0];
    for (int p = 0; p < NPORTS; p++) e[2*p +: 2] = 2'((seed + p) % 3 + 1);
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [ENTW-1:0] d);
    @(negedge clk); entWr = 1'b1; entWrData = d;
    @(negedge clk); entWr = 1'b0;
  endtask

  task automatic runCmd(input logic busyBit, input logic [1:0] op, input int vid, output int cyc);
    @(negedge clk); cmdWr = 1'b1; cmdWrData = {busyBit, 1'b0, op, 12'(vid)};
    @(negedge clk); cmdWr = 1'b0;
    cyc = 0;
    while (cmdRdData[15] && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input int vid);
    int c;
    runCmd(1'b1, op, vid, c);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdRdData[15:14] == 2'b00, "R1 busy/full after reset", cmdRdData[15:14], 0);
    chk(entRdData == '0, "R1 staging after reset", entRdData, 0);
    doCmd(READ, 100);
    chk(entRdData == MISS, "R1 table empty after reset", entRdData, MISS);
  endtask

  task automatic t_busyLen;
    int c;
    writeEntry(mkEntry(1));
    runCmd(1'b1, LOAD, 50, c);
    chk(c == DEPTH + 1, "R9 busy length", c, DEPTH + 1);
    chk(c > 0, "R2 busy set after start", c, DEPTH + 1);
    doCmd(READ, 50);
    chk(entRdData == {1'b1, mkEntry(1)[ENTW-2:0]}, "R4 read after load", entRdData, {1'b1, mkEntry(1)[ENTW-2:0]});
    doCmd(PURGE, 50);
  endtask

  task automatic t_ignore;
    int c;
    runCmd(1'b0, READ, 7, c);
    chk(c == 0, "R10 busy bit clear ignored", c, 0);
    runCmd(1'b1, 2'b00, 7, c);
    chk(c == 0, "R10 op 00 ignored", c, 0);
  endtask

  task automatic t_fill;
    int c;
    for (int i = 0; i < DEPTH; i++) begin
      writeEntry(mkEntry(i));
      doCmd(LOAD, 100 + i);
      chk(cmdRdData[14] == 1'b0, "R8 no full while slots free", cmdRdData[14], 0);
    end
    for (int i = 0; i < DEPTH; i += 5) begin
      doCmd(READ, 100 + i);
      chk(entRdData == {1'b1, mkEntry(i)[ENTW-2:0]}, "R4 read stored entry", entRdData, {1'b1, mkEntry(i)[ENTW-2:0]});
    end
    writeEntry(mkEntry(40));
    doCmd(LOAD, 200);
    chk(cmdRdData[14] == 1'b1, "R8 full on extra load", cmdRdData[14], 1);
    doCmd(READ, 200);
    chk(entRdData == MISS, "R8 table unchanged when full", entRdData, MISS);
    chk(cmdRdData[14] == 1'b0, "R8 full cleared by next command", cmdRdData[14], 0);
    writeEntry(mkEntry(77));
    doCmd(LOAD, 105);
    chk(cmdRdData[14] == 1'b0, "R5 overwrite uses no slot", cmdRdData[14], 0);
    doCmd(READ, 105);
    chk(entRdData == {1'b1, mkEntry(77)[ENTW-2:0]}, "R5 overwritten in place", entRdData, {1'b1, mkEntry(77)[ENTW-2:0]});
  endtask

  task automatic t_purge;
    doCmd(PURGE, 107);
    doCmd(READ, 107);
    chk(entRdData == MISS, "R7 purged entry misses", entRdData, MISS);
    writeEntry(mkEntry(40));
    doCmd(LOAD, 200);
    chk(cmdRdData[14] == 1'b0, "R7 freed slot reused", cmdRdData[14], 0);
    doCmd(READ, 200);
    chk(entRdData == {1'b1, mkEntry(40)[ENTW-2:0]}, "R7 new entry in freed slot", entRdData, {1'b1, mkEntry(40)[ENTW-2:0]});
    doCmd(READ, 3000);
    chk(entRdData == MISS, "R6 miss word", entRdData, MISS);
  endtask

  task automatic t_hold;
    writeEntry(mkEntry(2));
    @(negedge clk); cmdWr = 1'b1; cmdWrData = {1'b1, 1'b0, LOAD, 12'd300};
    @(negedge clk); cmdWr = 1'b0;
    repeat (3) @(negedge clk);
    entWr = 1'b1; entWrData = mkEntry(5);
    cmdWr = 1'b1; cmdWrData = {1'b1, 1'b0, READ, 12'd999};
    @(negedge clk); entWr = 1'b0; cmdWr = 1'b0;
    chk(cmdRdData[11:0] == 12'd300, "R3 command write ignored while busy", cmdRdData[11:0], 300);
    while (cmdRdData[15]) @(negedge clk);
    chk(entRdData == mkEntry(2), "R3 staging write ignored while busy", entRdData, mkEntry(2));
    doCmd(PURGE, 107);
    doCmd(READ, 300);
    chk(entRdData == {1'b1, mkEntry(2)[ENTW-2:0]}, "R3 load used pre-busy staging", entRdData, {1'b1, mkEntry(2)[ENTW-2:0]});
  endtask

  initial begin
    t_reset;
    t_ignore;
    t_busyLen;
    t_fill;
    t_purge;
    doCmd(PURGE, 200);
    t_hold;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule